// File: doc/BRIEF.md
# Sprite Blitter with XOR Collision Detect

This block keeps a 64 by 32 one-bit-per-pixel display image. It paints sprites onto that image. A sprite is eight pixels wide and between zero and fifteen rows tall. A start pulse supplies four values:

- the column and line of the sprite's top-left corner,
- the number of rows,
- the memory address of the first sprite byte.

For each row, the block reads one byte from an external byte-wide memory. It then flips the image pixels that line up with the set bits of that byte. Writing the same sprite twice at the same place therefore removes it again. A flag reports whether any pixel that was lit went dark during the draw.

Pixels that fall past the right edge continue at column 0. Rows that fall past the bottom continue at line 0. A separate clear request blanks the whole image one line per cycle. A read port returns any single pixel without waiting, for a video scan-out circuit. Each finished draw or clear ends with a one-cycle completion pulse. Requests that arrive while the block is busy are dropped.

Top module: `sprite_blitter`

## Requirements
- R1: After reset `busy`, `drawDone` and `collision` are 0 and every pixel reads 0.
- R2: A draw of N rows issues exactly N memory reads. Read k drives `memAddr` = (`baseAddr` + k) mod 4096 with `memRd` high for one cycle. The byte arrives on `memData` in the following cycle.
- R3: Bit 7 of sprite byte k lands on column X, line Y+k. Bit 7-b lands on column X+b. A set bit inverts the pixel and a clear bit leaves it unchanged.
- R4: Columns wrap: bit 7-b of a row lands on column (X+b) mod 64.
- R5: Lines wrap: row k of the sprite lands on line (Y+k) mod 32.
- R6: `collision` is cleared when a draw starts. It ends the draw at 1 exactly when some pixel went from 1 to 0. It holds that value until the next draw starts.
- R7: The cycle that samples `startDraw` is edge 0. `busy` is high from that edge until edge 2N. `drawDone` is high for exactly one cycle, after edge 2N, and `busy` is low in that cycle.
- R8: `startDraw` and `clearReq` are ignored while `busy` is high. They cause no reads and no pixel changes.
- R9: A clear request sets all 2048 pixels to 0. `drawDone` follows after edge 32 and `collision` keeps its value.
- R10: A draw with N = 0 reads no memory, changes no pixel, leaves `collision` at 0 and pulses `drawDone` after edge 0.
- R11: `scanPixel` shows the pixel at (`scanCol`, `scanRow`) combinationally. A value of 1 means the pixel is lit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startDraw | input | 1 | Begin a sprite draw |
| clearReq | input | 1 | Begin a full-screen clear (start wins if both) |
| xPos | input | 6 | Left column of the sprite |
| yPos | input | 5 | Top line of the sprite |
| rowCount | input | 4 | Sprite height N |
| baseAddr | input | 12 | Address of sprite row 0 |
| memAddr | output | 12 | Sprite memory read address |
| memRd | output | 1 | Sprite memory read strobe |
| memData | input | 8 | Sprite byte, valid one cycle after `memRd` |
| scanRow | input | 5 | Scan-out line select |
| scanCol | input | 6 | Scan-out column select |
| scanPixel | output | 1 | Selected pixel |
| busy | output | 1 | Draw or clear in progress |
| drawDone | output | 1 | One-cycle completion pulse |
| collision | output | 1 | A lit pixel was erased in the last draw |

## Verification
The bench places sprites at X = 60 and Y = 30. A design that clips instead of wrapping would leave pixels missing there, and one that wraps by the sprite width would put them at the wrong column. The bench also starts a draw at base address 0xFFE. A design that carries the address into bit 12, or indexes with a stale row counter, would present the wrong read addresses to the scoreboard.

A redraw over an existing sprite must raise `collision`. A draw that only adds pixels must leave it clear. A design that ORs pixels, or that does not reset the flag between draws, fails one of the two cases.

The bench also sends start and clear requests in the middle of a draw, runs an empty N = 0 draw, and times the completion pulse. Extra reads, a blanked image or a done pulse that is late or lasts two cycles each count as errors.

// File: rtl/blit_pkg.sv
package blit_pkg;
  parameter int SCR_W  = 64;
  parameter int SCR_H  = 32;
  parameter int SPR_W  = 8;
  parameter int ADDR_W = 12;
  parameter int CNT_W  = 4;

  localparam int COL_W = $clog2(SCR_W);
  localparam int ROW_W = $clog2(SCR_H);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_XOR   = 2'd2,
    ST_CLR   = 2'd3
  } blitState_t;

  typedef struct packed {
    logic             latchArgs;
    logic             fetch;
    logic             xorRow;
    logic             clrRow;
    logic [ROW_W-1:0] idx;
  } strobe_t;
endpackage

// File: rtl/blit_ctrl.sv
module blit_ctrl
  import blit_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             startDraw,
  input  logic             clearReq,
  input  logic [CNT_W-1:0] rowCount,
  output strobe_t          strb,
  output logic             busy,
  output logic             drawDone
);
  blitState_t       st;
  logic [ROW_W-1:0] idx;
  logic [CNT_W-1:0] nReg;
  logic             lastDrawRow;
  logic             lastClrRow;

  assign lastDrawRow = (idx + 1'b1) == ROW_W'(nReg);
  assign lastClrRow  = idx == ROW_W'(SCR_H - 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st       <= ST_IDLE;
      idx      <= '0;
      nReg     <= '0;
      drawDone <= 1'b0;
    end else begin
      drawDone <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (startDraw) begin
            nReg <= rowCount;
            idx  <= '0;
            if (rowCount == '0) drawDone <= 1'b1;
            else                st <= ST_FETCH;
          end else if (clearReq) begin
            idx <= '0;
            st  <= ST_CLR;
          end
        end
        ST_FETCH: st <= ST_XOR;
        ST_XOR: begin
          if (lastDrawRow) begin
            drawDone <= 1'b1;
            st       <= ST_IDLE;
          end else begin
            idx <= idx + 1'b1;
            st  <= ST_FETCH;
          end
        end
        ST_CLR: begin
          if (lastClrRow) begin
            drawDone <= 1'b1;
            st       <= ST_IDLE;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.latchArgs = (st == ST_IDLE) && startDraw;
    strb.fetch     = st == ST_FETCH;
    strb.xorRow    = st == ST_XOR;
    strb.clrRow    = st == ST_CLR;
    strb.idx       = idx;
  end

  assign busy = st != ST_IDLE;

  // R7: completion is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    drawDone |=> !drawDone);

  // R7: the block is idle when it signals completion
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    drawDone |-> !busy);

  // R8: no new job is accepted while one is running
  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strb.latchArgs);

  // R9: a clear sweep lasts until its last line, then stops
  p_clr_exit_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrRow && !lastClrRow) |=> strb.clrRow);
endmodule

// File: rtl/blit_datapath.sv
module blit_datapath
  import blit_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [COL_W-1:0]  xPos,
  input  logic [ROW_W-1:0]  yPos,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [SPR_W-1:0]  memData,
  input  logic [ROW_W-1:0]  scanRow,
  input  logic [COL_W-1:0]  scanCol,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic              collision,
  output logic              scanPixel
);
  logic [SCR_W-1:0]  fb [SCR_H];
  logic [COL_W-1:0]  xReg;
  logic [ROW_W-1:0]  yReg;
  logic [ADDR_W-1:0] baseReg;
  logic [ROW_W-1:0]  tgtRow;
  logic [SCR_W-1:0]  rowMask;
  logic [COL_W-1:0]  colOf [SPR_W];

  assign memAddr = baseReg + ADDR_W'(strb.idx);
  assign memRd   = strb.fetch;
  assign tgtRow  = yReg + strb.idx;

  for (genvar b = 0; b < SPR_W; b++) begin : g_col
    assign colOf[b] = xReg + COL_W'(b);
  end

  always_comb begin
    rowMask = '0;
    for (int b = 0; b < SPR_W; b++) begin
      rowMask[colOf[b]] = memData[SPR_W-1-b];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xReg    <= '0;
      yReg    <= '0;
      baseReg <= '0;
    end else if (strb.latchArgs) begin
      xReg    <= xPos;
      yReg    <= yPos;
      baseReg <= baseAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < SCR_H; r++) fb[r] <= '0;
    end else if (strb.clrRow) begin
      fb[strb.idx] <= '0;
    end else if (strb.xorRow) begin
      fb[tgtRow] <= fb[tgtRow] ^ rowMask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               collision <= 1'b0;
    else if (strb.latchArgs) collision <= 1'b0;
    else if (strb.xorRow)    collision <= collision | (|(fb[tgtRow] & rowMask));
  end

  assign scanPixel = fb[scanRow][scanCol];

  // R2: each row update consumes the byte fetched one cycle earlier
  p_fetch_before_xor_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.xorRow |-> $past(strb.fetch));

  // R6: the flag starts every draw cleared
  p_collide_reset_r6: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.latchArgs) |-> !collision);

  // R9: clearing, fetching and updating never overlap
  p_excl_strobes_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.fetch, strb.xorRow, strb.clrRow}));
endmodule

// File: rtl/sprite_blitter.sv
module sprite_blitter
  import blit_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startDraw,
  input  logic              clearReq,
  input  logic [COL_W-1:0]  xPos,
  input  logic [ROW_W-1:0]  yPos,
  input  logic [CNT_W-1:0]  rowCount,
  input  logic [ADDR_W-1:0] baseAddr,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  input  logic [SPR_W-1:0]  memData,
  input  logic [ROW_W-1:0]  scanRow,
  input  logic [COL_W-1:0]  scanCol,
  output logic              scanPixel,
  output logic              busy,
  output logic              drawDone,
  output logic              collision
);
  strobe_t strb;

  blit_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startDraw(startDraw),
    .clearReq (clearReq),
    .rowCount (rowCount),
    .strb     (strb),
    .busy     (busy),
    .drawDone (drawDone)
  );

  blit_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .xPos     (xPos),
    .yPos     (yPos),
    .baseAddr (baseAddr),
    .memData  (memData),
    .scanRow  (scanRow),
    .scanCol  (scanCol),
    .memAddr  (memAddr),
    .memRd    (memRd),
    .collision(collision),
    .scanPixel(scanPixel)
  );
endmodule

// File: tb/tb_sprite_blitter.sv
`timescale 1ns/1ps
module tb_sprite_blitter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startDraw = 1'b0;
  logic        clearReq = 1'b0;
  logic [5:0]  xPos = '0;
  logic [4:0]  yPos = '0;
  logic [3:0]  rowCount = '0;
  logic [11:0] baseAddr = '0;
  logic [11:0] memAddr;
  logic        memRd;
  logic [7:0]  memData = '0;
  logic [4:0]  scanRow = '0;
  logic [5:0]  scanCol = '0;
  logic        scanPixel, busy, drawDone, collision;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 0;

  logic [7:0]  mem [256];
  bit          shadow [32][64];
  logic [11:0] expAddrQ [$];

  always #2 clk = ~clk;

  sprite_blitter dut (
    .clk(clk), .rstN(rstN), .startDraw(startDraw), .clearReq(clearReq),
    .xPos(xPos), .yPos(yPos), .rowCount(rowCount), .baseAddr(baseAddr),
    .memAddr(memAddr), .memRd(memRd), .memData(memData),
    .scanRow(scanRow), .scanCol(scanCol), .scanPixel(scanPixel),
    .busy(busy), .drawDone(drawDone), .collision(collision)
  );

  // one-cycle-latency sprite memory
  always @(posedge clk) if (memRd) memData <= mem[memAddr[7:0]];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // scoreboard monitor: every read must match the next expected address (R2)
  always @(negedge clk) begin
    if (rstN && memRd) begin
      if (expAddrQ.size() == 0) begin
        chk(1'b0, "R2 unexpected read", int'(memAddr), -1);
      end else begin
        automatic logic [11:0] e = expAddrQ.pop_front();
        chk(memAddr == e, "R2 read address", int'(memAddr), int'(e));
      end
    end
  end

  task automatic cmpFb(input string tag);
    int bad = 0;
    int badAct = 0;
    int badExp = 0;
    for (int r = 0; r < 32; r++) begin
      for (int c = 0; c < 64; c++) begin
        scanRow = 5'(r);
        scanCol = 6'(c);
        #0.25;
        if (scanPixel !== shadow[r][c]) begin
          if (bad == 0) begin
            badAct = r * 1000 + c * 10 + int'(scanPixel);
            badExp = r * 1000 + c * 10 + int'(shadow[r][c]);
          end
          bad++;
        end
      end
    end
    chk(bad == 0, tag, badAct, badExp);
  endtask

  task automatic drawSprite(input int x, input int y, input int n, input int base,
                            input bit poke, input string tag);
    bit expColl = 0;
    int cnt;
    for (int k = 0; k < n; k++) begin
      automatic logic [11:0] a = 12'(base + k);
      automatic logic [7:0] byteV = mem[a[7:0]];
      automatic int row = (y + k) % 32;
      expAddrQ.push_back(a);
      for (int b = 0; b < 8; b++) begin
        automatic int col = (x + b) % 64;
        if (byteV[7-b]) begin
          if (shadow[row][col]) expColl = 1;
          shadow[row][col] = !shadow[row][col];
        end
      end
    end
    @(negedge clk);
    startDraw = 1'b1;
    xPos = 6'(x); yPos = 5'(y); rowCount = 4'(n); baseAddr = 12'(base);
    @(negedge clk);
    startDraw = 1'b0;
    cnt = 1;
    if (n > 0) chk(busy == 1'b1, {"R7 busy ", tag}, int'(busy), 1);
    while (!drawDone && cnt < 100) begin
      if (poke && cnt == 2) begin
        startDraw = 1'b1; clearReq = 1'b1;
        xPos = 6'd7; yPos = 5'd7; rowCount = 4'd9; baseAddr = 12'h0C0;
      end else begin
        startDraw = 1'b0; clearReq = 1'b0;
      end
      @(negedge clk);
      cnt++;
    end
    startDraw = 1'b0; clearReq = 1'b0;
    chk(cnt == 2 * n + 1, {"R7 done cycle ", tag}, cnt, 2 * n + 1);
    chk(busy == 1'b0, {"R7 idle at done ", tag}, int'(busy), 0);
    chk(collision == expColl, {"R6 collision ", tag}, int'(collision), int'(expColl));
    @(negedge clk);
    chk(drawDone == 1'b0, {"R7 pulse width ", tag}, int'(drawDone), 0);
    chk(collision == expColl, {"R6 hold ", tag}, int'(collision), int'(expColl));
    chk(expAddrQ.size() == 0, {"R2 read count ", tag}, expAddrQ.size(), 0);
    cmpFb({"R3 image ", tag});
  endtask

  task automatic clearScreen();
    logic prevColl = collision;
    int cnt;
    @(negedge clk);
    clearReq = 1'b1;
    @(negedge clk);
    clearReq = 1'b0;
    cnt = 1;
    while (!drawDone && cnt < 100) begin
      @(negedge clk);
      cnt++;
    end
    chk(cnt == 33, "R9 clear done cycle", cnt, 33);
    chk(collision == prevColl, "R9 collision kept", int'(collision), int'(prevColl));
    for (int r = 0; r < 32; r++) for (int c = 0; c < 64; c++) shadow[r][c] = 0;
    chk(expAddrQ.size() == 0, "R9 no reads", expAddrQ.size(), 0);
    cmpFb("R9 all pixels off");
  endtask

  initial begin
    #400000;
    if (!finished) begin
      nErrors++;
      nChecks++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37) ^ 8'hA5);
    mem[8'h40] = 8'h80;
    for (int r = 0; r < 32; r++) for (int c = 0; c < 64; c++) shadow[r][c] = 0;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(drawDone == 1'b0, "R1 done", int'(drawDone), 0);
    chk(collision == 1'b0, "R1 collision", int'(collision), 0);
    cmpFb("R1 blank image");

    // MSB is leftmost; direct scan-port probe (R3, R11)
    drawSprite(10, 3, 1, 'h40, 0, "msb");
    scanRow = 5'd3; scanCol = 6'd10; #0.25;
    chk(scanPixel == 1'b1, "R11 R3 msb pixel", int'(scanPixel), 1);
    scanCol = 6'd17; #0.25;
    chk(scanPixel == 1'b0, "R11 R3 lsb side pixel", int'(scanPixel), 0);

    drawSprite(0, 0, 5, 'h10, 0, "R3 basic");
    drawSprite(60, 8, 4, 'h20, 0, "R4 hwrap");
    drawSprite(20, 30, 5, 'h30, 0, "R5 vwrap");
    drawSprite(0, 0, 5, 'h10, 0, "R6 redraw");
    drawSprite(5, 5, 0, 'h50, 0, "R10 empty");
    drawSprite(40, 12, 4, 'hFFE, 0, "R2 addr wrap");
    drawSprite(33, 17, 15, 'h80, 0, "R3 tall");
    drawSprite(50, 26, 3, 'h60, 1, "R8 ignore");
    clearScreen();
    drawSprite(0, 0, 2, 'h10, 0, "R6 fresh");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end
endmodule